// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block is one DMA channel that walks a chain of transfer descriptors held in memory. Each descriptor gives a byte count, a source address, a destination address and a link to the next descriptor. Software writes the address of the first descriptor and sets the go bit in the mode register. The channel then fetches the descriptor and copies its bytes one at a time. It follows the link to the next descriptor and stops after the descriptor whose link word carries the end-of-list flag.

Progress and faults are reported through sticky event bits in a status register, and software clears each one by writing a one to it. A descriptor with a zero byte count raises the programming-error event but moves no data. Software can therefore place one in a chain as an interrupt-only marker. Software can halt a running walk through an abort bit. A mode-register write of all zeros returns the channel to its reset condition.

The memory side is a single request/acknowledge port. Descriptor words are fetched as 64-bit accesses, and payload is moved with byte accesses on the low eight data bits.

Top module: `dlw_chain_walker`

## Requirements
- R1: After reset the mode register, status register and count register all read zero, `irq` is low and `mem_req` is low.
- R2: A mode write with go (bit 0) set while idle fetches four 64-bit words: the count at the current-descriptor address, the source at +8, the destination at +16 and the link at +24. It then copies the count's bytes from source to destination in ascending order, touching no other destination byte.
- R3: A link word with bit 0 set ends the chain after that descriptor and sets end-of-list (status bit 5) and end-of-chain (status bit 6). It clears busy (status bit 0) and the go bit. In any other case the walk continues at the link address with its low five bits cleared, and the current and next registers (offsets 2 and 3) read back the last descriptor address and link word.
- R4: Each descriptor whose nonzero count is fully moved sets end-of-segment (status bit 4).
- R5: A descriptor with a zero count sets programming-error (status bit 3), moves no byte, leaves the count register (offset 4) at zero and does not set end-of-segment. The walk still goes on to the next link or ends at the end-of-list flag.
- R6: A count above `MAX_CNT` sets programming-error and stops the channel without moving any byte.
- R7: A start address with any of bits 4:0 set, or a link word without the end flag that has any of bits 4:1 set, sets transfer-error (status bit 2) and stops the channel. A misaligned start issues no memory access.
- R8: An acknowledge with `mem_err` high sets transfer-error and stops the channel.
- R9: Writing the status register (offset 1) clears each event bit 6:2 written as one and leaves the others. Bits 1:0 are read-only.
- R10: Setting abort (mode bit 1) during a walk stops the channel once the access in flight is acknowledged. The status then reads busy=1 and halted=1 (bit 1), with no further requests. A mode write with abort clear returns it to idle.
- R11: With external start (mode bit 2) set, a go write waits in busy state with no memory access until `ext_go` is pulsed.
- R12: `irq` is high exactly when an event is set whose enable is set: transfer- or programming-error with mode bit 3, end-of-segment with bit 4, end-of-list with bit 5, end-of-chain with bit 6.
- R13: A mode write of all zeros clears every status event, the count and next registers and the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset: 0 mode, 1 status, 2 current, 3 next, 4 count |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| ext_go | input | 1 | External start pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1: 64-bit descriptor access, 0: byte access |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 64 | Write data, byte in bits 7:0 |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for a request that is dropped or moved before its acknowledge, and for any request while idle or halted. It also checks that a pending abort turns into the halted state right after the next clean acknowledge, that end-of-list never rises while the channel stays busy, and that `irq` stays low with no event set. What only the bench scenarios can show is the copied data itself and the event mix each chain shape produces: zero-count markers, oversize counts, misaligned links, bus faults and external start. The exact decode of the interrupt enables is also left to the bench.

// File: rtl/dlw_pkg.sv
`timescale 1ns/1ps
package dlw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_DESC  = 3'd2,
        ST_LOAD  = 3'd3,
        ST_STORE = 3'd4,
        ST_HALT  = 3'd5
    } walk_st_e;

    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_CUR  = 3'd2;
    localparam logic [2:0] RA_NXT  = 3'd3;
    localparam logic [2:0] RA_CNT  = 3'd4;

    localparam int MB_GO    = 0;
    localparam int MB_ABORT = 1;
    localparam int MB_EXT   = 2;
    localparam int MB_IE_LO = 3;
    localparam int N_IE     = 4;

    localparam int EV_TE  = 0;
    localparam int EV_PE  = 1;
    localparam int EV_EOS = 2;
    localparam int EV_EOL = 3;
    localparam int EV_EOC = 4;
    localparam int EV_N   = 5;
    localparam int SB_EV_LO = 2;

    localparam int ALIGN_BITS = 5;
endpackage

// File: rtl/dlw_irq_merge.sv
`timescale 1ns/1ps
module dlw_irq_merge #(
    parameter int N = 5
) (
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = ev[i] & en[i];
    end

    assign irq = |hit;
endmodule

// File: rtl/dlw_rd_mux.sv
`timescale 1ns/1ps
module dlw_rd_mux #(
    parameter int AW = 32
) (
    input  logic [2:0]    sel,
    input  logic [6:0]    mode_w,
    input  logic [6:0]    stat_w,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] nxt,
    input  logic [63:0]   cnt,
    output logic [63:0]   rdata
);
    import dlw_pkg::*;

    always_comb begin
        rdata = '0;
        case (sel)
            RA_MODE: rdata = {57'b0, mode_w};
            RA_STAT: rdata = {57'b0, stat_w};
            RA_CUR:  rdata = 64'(cur);
            RA_NXT:  rdata = 64'(nxt);
            RA_CNT:  rdata = cnt;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dlw_chain_walker.sv
`timescale 1ns/1ps
module dlw_chain_walker #(
    parameter int AW      = 32,
    parameter int MAX_CNT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    input  logic          ext_go,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [63:0]   mem_rdata,
    output logic          irq
);
    import dlw_pkg::*;

    localparam logic [63:0] CNT_LIMIT = 64'(MAX_CNT);

    typedef struct packed {
        walk_st_e            st;
        logic [1:0]          idx;
        logic                go;
        logic                abort;
        logic                ext_en;
        logic [N_IE-1:0]     ie;
        logic                halt_req;
        logic [EV_N-1:0]     ev;
        logic [AW-1:0]       cur;
        logic [AW-1:0]       nxt;
        logic [AW-1:0]       src;
        logic [AW-1:0]       dst;
        logic [63:0]         cnt;
        logic [7:0]          data;
    } walk_t;

    walk_t q, d;

    logic          mode_wr;
    logic          mode_clr;
    logic          busy_w;
    logic          halted_w;
    logic          launch;
    logic          do_link;
    logic          fault;
    logic          to_halt;
    logic [AW-1:0] link_w;

    assign mode_wr  = reg_wr && (reg_addr == RA_MODE);
    assign mode_clr = mode_wr && (reg_wdata == 64'd0);
    assign busy_w   = (q.st != ST_IDLE);
    assign halted_w = (q.st == ST_HALT);

    always_comb begin
        d         = q;
        launch    = 1'b0;
        do_link   = 1'b0;
        fault     = 1'b0;
        to_halt   = 1'b0;
        link_w    = q.nxt;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        if (reg_wr && reg_addr == RA_STAT)
            d.ev = q.ev & ~reg_wdata[SB_EV_LO +: EV_N];

        if (mode_wr) begin
            d.go     = reg_wdata[MB_GO];
            d.abort  = reg_wdata[MB_ABORT];
            d.ext_en = reg_wdata[MB_EXT];
            d.ie     = reg_wdata[MB_IE_LO +: N_IE];
            if (reg_wdata[MB_ABORT] && busy_w && !halted_w)
                d.halt_req = 1'b1;
        end

        if (reg_wr && reg_addr == RA_CUR && !busy_w)
            d.cur = reg_wdata[AW-1:0];

        case (q.st)
            ST_IDLE: begin
                if (mode_wr && reg_wdata[MB_GO]) begin
                    if (reg_wdata[MB_EXT]) d.st = ST_ARM;
                    else                   launch = 1'b1;
                end
            end
            ST_ARM: begin
                if (q.halt_req)  to_halt = 1'b1;
                else if (ext_go) launch  = 1'b1;
            end
            ST_DESC: begin
                mem_req  = 1'b1;
                mem_wide = 1'b1;
                mem_addr = q.cur + AW'({q.idx, 3'b000});
                if (mem_ack) begin
                    if (mem_err) begin
                        fault = 1'b1;
                    end else begin
                        case (q.idx)
                            2'd0: d.cnt = mem_rdata;
                            2'd1: d.src = mem_rdata[AW-1:0];
                            2'd2: d.dst = mem_rdata[AW-1:0];
                            default: d.nxt = mem_rdata[AW-1:0];
                        endcase
                        if (q.halt_req) begin
                            to_halt = 1'b1;
                        end else if (q.idx != 2'd3) begin
                            d.idx = q.idx + 2'd1;
                        end else if (q.cnt == 64'd0) begin
                            d.ev[EV_PE] = 1'b1;
                            do_link     = 1'b1;
                            link_w      = mem_rdata[AW-1:0];
                        end else if (q.cnt > CNT_LIMIT) begin
                            d.ev[EV_PE] = 1'b1;
                            d.st        = ST_IDLE;
                            d.go        = 1'b0;
                        end else begin
                            d.st = ST_LOAD;
                        end
                    end
                end
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = q.src;
                if (mem_ack) begin
                    if (mem_err) begin
                        fault = 1'b1;
                    end else begin
                        d.data = mem_rdata[7:0];
                        d.src  = q.src + AW'(1);
                        if (q.halt_req) to_halt = 1'b1;
                        else            d.st    = ST_STORE;
                    end
                end
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.dst;
                mem_wdata = {56'b0, q.data};
                if (mem_ack) begin
                    if (mem_err) begin
                        fault = 1'b1;
                    end else begin
                        d.dst = q.dst + AW'(1);
                        d.cnt = q.cnt - 64'd1;
                        if (q.cnt == 64'd1)
                            d.ev[EV_EOS] = 1'b1;
                        if (q.halt_req)           to_halt = 1'b1;
                        else if (q.cnt == 64'd1)  do_link = 1'b1;
                        else                      d.st    = ST_LOAD;
                    end
                end
            end
            ST_HALT: begin
                if (!q.abort) begin
                    d.st = ST_IDLE;
                    d.go = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (launch) begin
            if (q.cur[ALIGN_BITS-1:0] != '0) begin
                fault = 1'b1;
            end else begin
                d.st  = ST_DESC;
                d.idx = 2'd0;
            end
        end

        if (do_link) begin
            if (link_w[0]) begin
                d.ev[EV_EOL] = 1'b1;
                d.ev[EV_EOC] = 1'b1;
                d.st         = ST_IDLE;
                d.go         = 1'b0;
            end else if (link_w[ALIGN_BITS-1:1] != '0) begin
                fault = 1'b1;
            end else begin
                d.cur = {link_w[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                d.st  = ST_DESC;
                d.idx = 2'd0;
            end
        end

        if (fault) begin
            d.ev[EV_TE] = 1'b1;
            d.st        = ST_IDLE;
            d.go        = 1'b0;
        end

        if (to_halt) begin
            d.st       = ST_HALT;
            d.halt_req = 1'b0;
        end

        if (d.st == ST_IDLE)
            d.halt_req = 1'b0;

        if (mode_clr) begin
            d.st       = ST_IDLE;
            d.ev       = '0;
            d.cnt      = '0;
            d.nxt      = '0;
            d.halt_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    dlw_rd_mux #(.AW(AW)) u_rd (
        .sel    (reg_addr),
        .mode_w ({q.ie, q.ext_en, q.abort, q.go}),
        .stat_w ({q.ev, halted_w, busy_w}),
        .cur    (q.cur),
        .nxt    (q.nxt),
        .cnt    (q.cnt),
        .rdata  (reg_rdata)
    );

    dlw_irq_merge #(.N(EV_N)) u_irq (
        .ev  (q.ev),
        .en  ({q.ie[3], q.ie[2], q.ie[1], q.ie[0], q.ie[0]}),
        .irq (irq)
    );
endmodule

// File: rtl/dlw_chain_walker_chk.sv
`timescale 1ns/1ps
module dlw_chain_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          halted,
    input logic          halt_req,
    input logic          mode_clr,
    input logic [4:0]    ev,
    input logic          irq
);
    // R2: a request stays up with the same address until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mode_clr |=> mem_req && $stable(mem_addr));

    // R2: no memory traffic while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10: a halted channel issues nothing
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R10: pending abort takes effect right after a clean acknowledge
    p_halt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !halted && halt_req && mem_ack && !mem_err && !mode_clr |=> halted);

    // R3: end-of-list only appears together with the channel going idle
    p_eol_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[3]) |-> !busy);

    // R12: no event, no interrupt
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == 5'd0) |-> !irq);
endmodule

bind dlw_chain_walker dlw_chain_walker_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .busy     (busy_w),
    .halted   (halted_w),
    .halt_req (q.halt_req),
    .mode_clr (mode_clr),
    .ev       (q.ev),
    .irq      (irq)
);

// File: tb/tb_dlw_chain_walker.sv
`timescale 1ns/1ps
module tb_dlw_chain_walker;
    localparam int AW = 32;
    localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_CUR = 3'd2, A_NXT = 3'd3, A_CNT = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          ext_go = 1'b0;
    logic          mem_req, mem_we, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          irq;

    logic [7:0]    mem [0:2047];
    int            n_acc = 0;
    int            n_wr  = 0;
    logic          err_on = 1'b0;
    logic [AW-1:0] err_at = '0;
    int            n_chk = 0;
    int            n_bad = 0;
    logic          done  = 1'b0;

    always #10 clk = ~clk;

    dlw_chain_walker #(.AW(AW), .MAX_CNT(64)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_go(ext_go),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            n_acc   <= n_acc + 1;
            if (err_on && mem_addr == err_at) mem_err <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[10:0]] <= mem_wdata[7:0];
                n_wr <= n_wr + 1;
            end else if (mem_wide) begin
                for (int k = 0; k < 8; k++)
                    mem_rdata[8*k +: 8] <= mem[mem_addr[10:0] + 11'(k)];
            end else begin
                mem_rdata <= {56'b0, mem[mem_addr[10:0]]};
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic put64(input int a, input logic [63:0] v);
        for (int k = 0; k < 8; k++) mem[a + k] = v[8*k +: 8];
    endtask

    task automatic desc(input int a, input longint cnt, input longint src,
                        input longint dst, input longint nxt);
        put64(a, 64'(cnt));
        put64(a + 8, 64'(src));
        put64(a + 16, 64'(dst));
        put64(a + 24, 64'(nxt));
    endtask

    task automatic fill(input int src, input int dst, input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            mem[src + i] = 8'((i * 7 + seed) & 8'hff);
            mem[dst + i] = 8'h00;
        end
        mem[dst + len] = 8'hEE;
    endtask

    function automatic int mism(input int src, input int dst, input int len);
        int m = 0;
        for (int i = 0; i < len; i++) if (mem[dst + i] !== mem[src + i]) m++;
        return m;
    endfunction

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rreg(A_STAT, v);
            if (!v[0]) break;
        end
    endtask

    localparam logic [47:0] VEC [0:3] = '{
        {16'h0400, 16'h0600, 16'd1},
        {16'h0440, 16'h0640, 16'd5},
        {16'h0480, 16'h0680, 16'd17},
        {16'h0500, 16'h0700, 16'd64}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int w0, a0;
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(A_MODE, v); check("R1 mode", v, 64'h0);
        rreg(A_STAT, v); check("R1 stat", v, 64'h0);
        rreg(A_CNT, v);  check("R1 cnt", v, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 req", 64'(mem_req), 64'h0);

        // R2 R4 R3 single-descriptor copies from the table
        for (int n = 0; n < 4; n++) begin
            int s, t, c;
            s = int'(VEC[n][47:32]); t = int'(VEC[n][31:16]); c = int'(VEC[n][15:0]);
            fill(s, t, c, n + 3);
            desc(0, c, s, t, 1);
            w0 = n_wr;
            wreg(A_CUR, 64'h0);
            wreg(A_MODE, 64'h79);
            wait_idle();
            check("R2 bytes match", 64'(mism(s, t, c)), 64'h0);
            check("R2 write count", 64'(n_wr - w0), 64'(c));
            check("R2 guard byte", 64'(mem[t + c]), 64'hEE);
            rreg(A_STAT, v); check("R4 R3 events", v, 64'h70);
            rreg(A_MODE, v); check("R3 go cleared", v, 64'h78);
            wreg(A_STAT, 64'h7C);
        end

        // R3 R5 chain of three with a zero-count marker in the middle
        fill(16'h400, 16'h600, 3, 11);
        fill(16'h410, 16'h610, 2, 29);
        desc(32'h000, 3, 32'h400, 32'h600, 32'h020);
        desc(32'h020, 0, 32'h0, 32'h0, 32'h040);
        desc(32'h040, 2, 32'h410, 32'h610, 32'h081);
        w0 = n_wr;
        wreg(A_CUR, 64'h0);
        wreg(A_MODE, 64'h79);
        wait_idle();
        check("R3 chain writes", 64'(n_wr - w0), 64'd5);
        check("R3 chain data", 64'(mism(16'h400, 16'h600, 3) + mism(16'h410, 16'h610, 2)), 64'h0);
        rreg(A_STAT, v); check("R5 chain events", v, 64'h78);
        rreg(A_CUR, v);  check("R3 cur readback", v, 64'h40);
        rreg(A_NXT, v);  check("R3 next readback", v, 64'h81);
        rreg(A_CNT, v);  check("R3 cnt zero", v, 64'h0);
        wreg(A_STAT, 64'h7C);

        // R5 zero count alone
        desc(32'h080, 0, 32'h0, 32'h0, 32'h001);
        w0 = n_wr;
        wreg(A_CUR, 64'h80);
        wreg(A_MODE, 64'h79);
        wait_idle();
        rreg(A_STAT, v); check("R5 zero events", v, 64'h68);
        rreg(A_CNT, v);  check("R5 cnt stays zero", v, 64'h0);
        check("R5 no writes", 64'(n_wr - w0), 64'h0);
        wreg(A_STAT, 64'h7C);

        // R6 oversize count
        desc(32'h0A0, 65, 32'h400, 32'h600, 32'h001);
        w0 = n_wr;
        wreg(A_CUR, 64'hA0);
        wreg(A_MODE, 64'h79);
        wait_idle();
        rreg(A_STAT, v); check("R6 oversize events", v, 64'h08);
        check("R6 no writes", 64'(n_wr - w0), 64'h0);

        // R13 mode write of zero
        wreg(A_MODE, 64'h0);
        rreg(A_STAT, v); check("R13 stat cleared", v, 64'h0);
        rreg(A_CNT, v);  check("R13 cnt cleared", v, 64'h0);
        rreg(A_NXT, v);  check("R13 next cleared", v, 64'h0);
        rreg(A_MODE, v); check("R13 mode cleared", v, 64'h0);

        // R7 misaligned link
        fill(16'h400, 16'h7F0, 1, 5);
        desc(32'h0C0, 1, 32'h400, 32'h7F0, 32'h0E8);
        w0 = n_wr;
        wreg(A_CUR, 64'hC0);
        wreg(A_MODE, 64'h79);
        wait_idle();
        rreg(A_STAT, v); check("R7 bad link events", v, 64'h14);
        check("R7 bad link writes", 64'(n_wr - w0), 64'd1);
        wreg(A_STAT, 64'h7C);

        // R7 misaligned start
        a0 = n_acc;
        wreg(A_CUR, 64'h08);
        wreg(A_MODE, 64'h79);
        repeat (4) @(negedge clk);
        rreg(A_STAT, v); check("R7 bad start events", v, 64'h04);
        check("R7 bad start no access", 64'(n_acc - a0), 64'h0);
        wreg(A_STAT, 64'h7C);

        // R8 bus error on first store
        fill(16'h400, 16'h600, 3, 9);
        desc(32'h0E0, 3, 32'h400, 32'h600, 32'h001);
        err_on = 1'b1; err_at = 32'h600;
        wreg(A_CUR, 64'hE0);
        wreg(A_MODE, 64'h79);
        wait_idle();
        err_on = 1'b0;
        rreg(A_STAT, v); check("R8 bus error events", v, 64'h04);

        // R9 write-one-to-clear
        desc(32'h080, 0, 32'h0, 32'h0, 32'h001);
        wreg(A_CUR, 64'h80);
        wreg(A_MODE, 64'h79);
        wait_idle();
        rreg(A_STAT, v); check("R9 pre", v, 64'h6C);
        wreg(A_STAT, 64'h08);
        rreg(A_STAT, v); check("R9 one cleared", v, 64'h64);
        wreg(A_STAT, 64'h03);
        rreg(A_STAT, v); check("R9 read-only bits", v, 64'h64);
        wreg(A_STAT, 64'h00);
        rreg(A_STAT, v); check("R9 zero write", v, 64'h64);

        // R12 interrupt enables (events: te, eol, eoc)
        wreg(A_MODE, 64'h08); #1; check("R12 err enable te", 64'(irq), 64'h1);
        wreg(A_STAT, 64'h04);
        wreg(A_MODE, 64'h08); #1; check("R12 err enable no err", 64'(irq), 64'h0);
        wreg(A_MODE, 64'h10); #1; check("R12 seg enable", 64'(irq), 64'h0);
        wreg(A_MODE, 64'h20); #1; check("R12 eol enable", 64'(irq), 64'h1);
        wreg(A_MODE, 64'h40); #1; check("R12 eot enable", 64'(irq), 64'h1);
        wreg(A_STAT, 64'h7C);
        wreg(A_MODE, 64'h78); #1; check("R12 no events", 64'(irq), 64'h0);

        // R10 abort during a long segment
        fill(16'h400, 16'h600, 40, 1);
        desc(32'h100, 40, 32'h400, 32'h600, 32'h001);
        w0 = n_wr;
        wreg(A_CUR, 64'h100);
        wreg(A_MODE, 64'h79);
        repeat (30) @(negedge clk);
        wreg(A_MODE, 64'h7B);
        repeat (20) @(negedge clk);
        rreg(A_STAT, v); check("R10 halted busy", v & 64'h3, 64'h3);
        check("R10 no request", 64'(mem_req), 64'h0);
        check("R10 stopped early", 64'((n_wr - w0) < 40), 64'h1);
        wreg(A_MODE, 64'h78);
        @(negedge clk);
        rreg(A_STAT, v); check("R10 back to idle", v & 64'h3, 64'h0);
        wreg(A_STAT, 64'h7C);

        // R11 external start
        fill(16'h400, 16'h600, 4, 17);
        desc(32'h100, 4, 32'h400, 32'h600, 32'h001);
        a0 = n_acc; w0 = n_wr;
        wreg(A_MODE, 64'h7D);
        repeat (10) @(negedge clk);
        rreg(A_STAT, v); check("R11 armed busy", v & 64'h3, 64'h1);
        check("R11 no access before pulse", 64'(n_acc - a0), 64'h0);
        @(negedge clk); ext_go = 1'b1;
        @(negedge clk); ext_go = 1'b0;
        wait_idle();
        check("R11 writes after pulse", 64'(n_wr - w0), 64'd4);
        rreg(A_STAT, v); check("R11 events", v, 64'h70);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule